// File: doc/BRIEF.md
# Banked Register File for a 16-bit Core

This block stores the programmer-visible registers of a small 16-bit processor core. Two identical banks each carry four data registers (R0 to R3), two address registers (A0, A1) and a frame base (FB). The program counter, the interrupt table base, the user and interrupt stack pointers, the static base and the flag word exist once and are never banked. One bit of the flag word chooses the bank used by every banked access. Another flag bit chooses which stack pointer answers to the "active stack pointer" code.

The core drives two combinational read ports and one write port. Each port carries a 4-bit register code and a 2-bit size. A byte access reaches one half of R0 or R1. A word access reaches any register. A pair access treats R2:R0 or R3:R1 as one 32-bit operand. The block does no decoding beyond this. It stores, selects and updates values only.

Register codes: 0 R0, 1 R1, 2 R2, 3 R3, 4 A0, 5 A1, 6 FB, 7 PC, 8 table base upper, 9 table base lower, 10 active SP, 11 USP, 12 ISP, 13 SB, 14 FLG, 15 unused. Size codes: 0 low byte, 1 high byte, 2 word, 3 pair.

Top module: `banked_regfile`

## Requirements
- R1: While `rst` is high on a clock edge, every register clears to zero. This leaves bank 0 selected and the interrupt stack pointer active.
- R2: Flag bit 4 selects the bank for codes 0 to 6. A write to one bank never changes the other bank.
- R3: Size 0 reaches bits 7:0 and size 1 reaches bits 15:8, on codes 0 and 1 only. A byte write leaves the other half unchanged. A byte read returns the half zero-extended to 32 bits.
- R4: Size 3 on code 0 reads and writes {R2,R0}, and on code 1 reads and writes {R3,R1}. The upper register holds bits 31:16.
- R5: The program counter is 20 bits wide. A word write stores `wr_data[19:0]`, and a read returns it zero-extended. Code 8 holds the 4-bit upper part of the table base and code 9 holds the 16-bit lower part.
- R6: Code 10 reaches USP when flag bit 7 is 1 and ISP when it is 0. Codes 11 and 12 always reach USP and ISP directly.
- R7: The flag word holds carry (bit 0), debug (1), zero (2), sign (3), bank select (4), overflow (5), interrupt enable (6), stack select (7) and a 3-bit priority level (bits 14:12). All other bits read as zero, whatever is written to them.
- R8: Reads return the register contents from before the current edge's write. Reads and the write both use the bank selected before a flag update made in the same cycle.
- R9: Byte or pair sizes on codes other than 0 and 1, and any access to code 15, read as zero and leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_sel | input | 4 | Read port A register code |
| rd_a_size | input | 2 | Read port A size code |
| rd_a_data | output | 32 | Read port A data |
| rd_b_sel | input | 4 | Read port B register code |
| rd_b_size | input | 2 | Read port B size code |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Write register code |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data |

## Verification
Reads are combinational. A corrupted register therefore shows on any read port in the same cycle that its code is presented, and a bad write shows on the first read after the edge. A wrong bank or stack bit shows in a different way: one register code starts returning the contents of its twin in the other bank or the other stack pointer. A lost byte merge shows as a changed neighbouring half on the next word read. The random mix reads every code often, so a bad state is usually caught within a few cycles.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [3:0]            rd_a_sel,
  input  logic [1:0]            rd_a_size,
  output logic [2*WORD_W-1:0]   rd_a_data,
  input  logic [3:0]            rd_b_sel,
  input  logic [1:0]            rd_b_size,
  output logic [2*WORD_W-1:0]   rd_b_data,
  input  logic                  wr_en,
  input  logic [3:0]            wr_sel,
  input  logic [1:0]            wr_size,
  input  logic [2*WORD_W-1:0]   wr_data
);
  localparam int unsigned PAIR_W = 2 * WORD_W;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned TBH_W  = ADDR_W - WORD_W;
  localparam int unsigned NREG   = 7;

  localparam logic [3:0] C_R0 = 4'd0, C_R1 = 4'd1, C_R2 = 4'd2, C_R3 = 4'd3;
  localparam logic [3:0] C_A0 = 4'd4, C_FB = 4'd6, C_PC = 4'd7;
  localparam logic [3:0] C_TBH = 4'd8, C_TBL = 4'd9, C_SP = 4'd10;
  localparam logic [3:0] C_USP = 4'd11, C_ISP = 4'd12, C_SB = 4'd13, C_FLG = 4'd14;
  localparam logic [1:0] SZ_LO = 2'd0, SZ_HI = 2'd1, SZ_WORD = 2'd2, SZ_PAIR = 2'd3;
  localparam logic [WORD_W-1:0] FLG_MASK = WORD_W'(16'h70FF);
  localparam int unsigned BANK_BIT = 4;
  localparam int unsigned SPSEL_BIT = 7;

  logic [WORD_W-1:0] bank_q [2][NREG];
  logic [ADDR_W-1:0] pc_q;
  logic [TBH_W-1:0]  tbh_q;
  logic [WORD_W-1:0] tbl_q, usp_q, isp_q, sb_q, flg_q;

  logic bnk, use_usp;
  assign bnk     = flg_q[BANK_BIT];
  assign use_usp = flg_q[SPSEL_BIT];

  function automatic logic [PAIR_W-1:0] read_reg(input logic [3:0] sel, input logic [1:0] sz);
    logic [WORD_W-1:0] w;
    logic [PAIR_W-1:0] r;
    logic split;
    split = (sel == C_R0) || (sel == C_R1);
    w = '0;
    r = '0;
    if (sel <= C_FB) w = bank_q[bnk][sel[2:0]];
    case (sz)
      SZ_LO:   if (split) r = PAIR_W'(w[HALF_W-1:0]);
      SZ_HI:   if (split) r = PAIR_W'(w[WORD_W-1:HALF_W]);
      SZ_PAIR: if (split) r = {bank_q[bnk][sel[0] ? 3 : 2], w};
      default: begin
        case (sel)
          C_PC:    r = PAIR_W'(pc_q);
          C_TBH:   r = PAIR_W'(tbh_q);
          C_TBL:   r = PAIR_W'(tbl_q);
          C_SP:    r = PAIR_W'(use_usp ? usp_q : isp_q);
          C_USP:   r = PAIR_W'(usp_q);
          C_ISP:   r = PAIR_W'(isp_q);
          C_SB:    r = PAIR_W'(sb_q);
          C_FLG:   r = PAIR_W'(flg_q);
          4'd15:   r = '0;
          default: r = PAIR_W'(w);
        endcase
      end
    endcase
    return r;
  endfunction

  always_comb rd_a_data = read_reg(rd_a_sel, rd_a_size);
  always_comb rd_b_data = read_reg(rd_b_sel, rd_b_size);

  logic is_split, is_word;
  assign is_split = (wr_sel == C_R0) || (wr_sel == C_R1);
  assign is_word  = (wr_size == SZ_WORD);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NREG; i++)
          bank_q[b][i] <= '0;
      pc_q  <= '0;
      tbh_q <= '0;
      tbl_q <= '0;
      usp_q <= '0;
      isp_q <= '0;
      sb_q  <= '0;
      flg_q <= '0;
    end else if (wr_en) begin
      if (wr_sel <= C_FB) begin
        if (is_word)
          bank_q[bnk][wr_sel[2:0]] <= wr_data[WORD_W-1:0];
        else if (is_split) begin
          case (wr_size)
            SZ_LO: bank_q[bnk][wr_sel[2:0]][HALF_W-1:0] <= wr_data[HALF_W-1:0];
            SZ_HI: bank_q[bnk][wr_sel[2:0]][WORD_W-1:HALF_W] <= wr_data[HALF_W-1:0];
            default: begin
              bank_q[bnk][wr_sel[2:0]] <= wr_data[WORD_W-1:0];
              bank_q[bnk][wr_sel[0] ? 3 : 2] <= wr_data[PAIR_W-1:WORD_W];
            end
          endcase
        end
      end else if (is_word) begin
        case (wr_sel)
          C_PC:  pc_q  <= wr_data[ADDR_W-1:0];
          C_TBH: tbh_q <= wr_data[TBH_W-1:0];
          C_TBL: tbl_q <= wr_data[WORD_W-1:0];
          C_SP:  if (use_usp) usp_q <= wr_data[WORD_W-1:0];
                 else         isp_q <= wr_data[WORD_W-1:0];
          C_USP: usp_q <= wr_data[WORD_W-1:0];
          C_ISP: isp_q <= wr_data[WORD_W-1:0];
          C_SB:  sb_q  <= wr_data[WORD_W-1:0];
          C_FLG: flg_q <= wr_data[WORD_W-1:0] & FLG_MASK;
          default: ;
        endcase
      end
    end
  end

  logic [NREG*WORD_W-1:0] bank0_flat, bank1_flat;
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      bank0_flat[i*WORD_W +: WORD_W] = bank_q[0][i];
      bank1_flat[i*WORD_W +: WORD_W] = bank_q[1][i];
    end
  end

  logic [WORD_W-1:0] cur_r0, cur_r1, cur_r3;
  assign cur_r0 = bank_q[bnk][0];
  assign cur_r1 = bank_q[bnk][1];
  assign cur_r3 = bank_q[bnk][3];

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flg_q == '0 && pc_q == '0 && isp_q == '0 && bank0_flat == '0));

  p_bank_isolate_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bnk) |=> $stable(bank1_flat));

  p_bank_isolate_b_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bnk) |=> $stable(bank0_flat));

  p_byte_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == C_R0 && wr_size == SZ_LO) |=>
      (cur_r0[WORD_W-1:HALF_W] == $past(cur_r0[WORD_W-1:HALF_W])));

  p_pair_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == C_R1 && wr_size == SZ_PAIR) |=> ({cur_r3, cur_r1} == $past(wr_data)));

  p_pc_width_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == C_PC && wr_size == SZ_WORD) |=> (pc_q == $past(wr_data[ADDR_W-1:0])));

  p_sp_alias_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == C_SP && use_usp) |=> $stable(isp_q));

  p_flag_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == C_FLG && wr_size == SZ_WORD) |=>
      (flg_q == ($past(wr_data[WORD_W-1:0]) & FLG_MASK)));

  p_ignore_size_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == C_A0 && wr_size != SZ_WORD) |=>
      ($stable(bank0_flat) && $stable(bank1_flat)));

endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  logic clk = 1'b0;
  logic rst;
  logic [3:0] rd_a_sel, rd_b_sel, wr_sel;
  logic [1:0] rd_a_size, rd_b_size, wr_size;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic wr_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst(rst),
    .rd_a_sel(rd_a_sel), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data)
  );

  logic [15:0] m_bank [2][7];
  logic [19:0] m_pc;
  logic [3:0]  m_tbh;
  logic [15:0] m_tbl, m_usp, m_isp, m_sb, m_flg;

  task automatic m_reset();
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 7; i++) m_bank[b][i] = 16'h0;
    m_pc = 0; m_tbh = 0; m_tbl = 0; m_usp = 0; m_isp = 0; m_sb = 0; m_flg = 0;
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] s, input logic [1:0] z);
    int b;
    b = m_flg[4];
    if (s <= 1) begin
      if (z == 0) return {24'h0, m_bank[b][s][7:0]};
      if (z == 1) return {24'h0, m_bank[b][s][15:8]};
      if (z == 3) return {m_bank[b][s + 2], m_bank[b][s]};
      return {16'h0, m_bank[b][s]};
    end
    if (z != 2) return 32'h0;
    if (s <= 6) return {16'h0, m_bank[b][s]};
    case (s)
      7:  return {12'h0, m_pc};
      8:  return {28'h0, m_tbh};
      9:  return {16'h0, m_tbl};
      10: return {16'h0, m_flg[7] ? m_usp : m_isp};
      11: return {16'h0, m_usp};
      12: return {16'h0, m_isp};
      13: return {16'h0, m_sb};
      14: return {16'h0, m_flg};
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_write(input logic [3:0] s, input logic [1:0] z, input logic [31:0] d);
    int b;
    b = m_flg[4];
    if (s <= 1) begin
      case (z)
        0: m_bank[b][s][7:0]  = d[7:0];
        1: m_bank[b][s][15:8] = d[7:0];
        2: m_bank[b][s]       = d[15:0];
        default: begin m_bank[b][s] = d[15:0]; m_bank[b][s + 2] = d[31:16]; end
      endcase
    end else if (z == 2) begin
      if (s <= 6) m_bank[b][s] = d[15:0];
      else case (s)
        7:  m_pc  = d[19:0];
        8:  m_tbh = d[3:0];
        9:  m_tbl = d[15:0];
        10: if (m_flg[7]) m_usp = d[15:0]; else m_isp = d[15:0];
        11: m_usp = d[15:0];
        12: m_isp = d[15:0];
        13: m_sb  = d[15:0];
        14: m_flg = d[15:0] & 16'h70FF;
        default: ;
      endcase
    end
  endtask

  function automatic string req_of(input logic [3:0] s, input logic [1:0] z);
    if (s == 15) return "R9";
    if (s <= 1 && z <= 1) return "R3";
    if (s <= 1 && z == 3) return "R4";
    if (z != 2) return "R9";
    if (s <= 6) return "R2";
    if (s <= 9) return "R5";
    if (s <= 13 && s != 13) return "R6";
    if (s == 14) return "R7";
    return "R8";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [3:0] ws, input logic [1:0] wz, input logic [31:0] wd,
                      input logic [3:0] as, input logic [1:0] az,
                      input logic [3:0] bs, input logic [1:0] bz, input string tag);
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_size = wz; wr_data = wd;
    rd_a_sel = as; rd_a_size = az; rd_b_sel = bs; rd_b_size = bz;
    #1;
    chk(tag, rd_a_data, m_read(as, az));
    chk(tag, rd_b_data, m_read(bs, bz));
    @(posedge clk);
    if (we) m_write(ws, wz, wd);
  endtask

  task automatic wr(input logic [3:0] s, input logic [1:0] z, input logic [31:0] d, input string tag);
    step(1'b1, s, z, d, s, 2'd2, 4'd0, 2'd2, tag);
  endtask

  task automatic rdw(input logic [3:0] s, input logic [31:0] exp, input string tag);
    @(negedge clk);
    wr_en = 0; rd_a_sel = s; rd_a_size = 2'd2; rd_b_sel = 4'd15; rd_b_size = 2'd2;
    #1;
    chk(tag, rd_a_data, exp);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0042);
    rst = 1; wr_en = 0; wr_sel = 0; wr_size = 2; wr_data = 0;
    rd_a_sel = 0; rd_a_size = 2; rd_b_sel = 0; rd_b_size = 2;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: reset state on every code
    for (int s = 0; s < 16; s++) rdw(4'(s), 32'h0, "R1");

    // R2: bank isolation
    wr(4'd0, 2'd2, 32'h1111, "R2");
    wr(4'd6, 2'd2, 32'h6666, "R2");
    wr(4'd14, 2'd2, 32'h0010, "R2");
    rdw(4'd0, 32'h0, "R2");
    wr(4'd0, 2'd2, 32'h2222, "R2");
    rdw(4'd0, 32'h2222, "R2");
    wr(4'd14, 2'd2, 32'h0000, "R2");
    rdw(4'd0, 32'h1111, "R2");
    rdw(4'd6, 32'h6666, "R2");

    // R3: byte halves
    wr(4'd0, 2'd2, 32'hABCD, "R3");
    wr(4'd0, 2'd0, 32'hFF12, "R3");
    rdw(4'd0, 32'hAB12, "R3");
    wr(4'd1, 2'd2, 32'h0000, "R3");
    wr(4'd1, 2'd1, 32'h0077, "R3");
    rdw(4'd1, 32'h7700, "R3");
    step(1'b0, 0, 0, 0, 4'd0, 2'd1, 4'd1, 2'd0, "R3");

    // R4: pairs
    wr(4'd0, 2'd3, 32'hDEADBEEF, "R4");
    rdw(4'd2, 32'hDEAD, "R4");
    rdw(4'd0, 32'hBEEF, "R4");
    wr(4'd3, 2'd2, 32'h1234, "R4");
    step(1'b0, 0, 0, 0, 4'd1, 2'd3, 4'd0, 2'd3, "R4");

    // R5: PC width and table base parts
    wr(4'd7, 2'd2, 32'hFFFFFFFF, "R5");
    rdw(4'd7, 32'h000FFFFF, "R5");
    wr(4'd8, 2'd2, 32'hFFFF, "R5");
    rdw(4'd8, 32'h0000000F, "R5");

    // R6: stack pointer selection
    wr(4'd10, 2'd2, 32'h0AAA, "R6");
    rdw(4'd12, 32'h0AAA, "R6");
    wr(4'd14, 2'd2, 32'h0080, "R6");
    wr(4'd10, 2'd2, 32'h0BBB, "R6");
    rdw(4'd11, 32'h0BBB, "R6");
    rdw(4'd12, 32'h0AAA, "R6");
    wr(4'd14, 2'd2, 32'h0000, "R6");
    rdw(4'd10, 32'h0AAA, "R6");

    // R7: reserved flag bits
    wr(4'd14, 2'd2, 32'hFFFF, "R7");
    rdw(4'd14, 32'h70FF, "R7");
    wr(4'd14, 2'd2, 32'h0000, "R7");

    // R8: old value on same-cycle access; bank before flag update
    step(1'b1, 4'd0, 2'd2, 32'h5A5A, 4'd0, 2'd2, 4'd0, 2'd0, "R8");
    rdw(4'd0, 32'h5A5A, "R8");
    step(1'b1, 4'd14, 2'd2, 32'h0010, 4'd0, 2'd2, 4'd14, 2'd2, "R8");
    rdw(4'd0, 32'h2222, "R8");
    wr(4'd14, 2'd2, 32'h0000, "R8");

    // R9: ignored sizes and unused code
    wr(4'd4, 2'd2, 32'h4444, "R9");
    wr(4'd4, 2'd0, 32'hFFFF, "R9");
    wr(4'd4, 2'd3, 32'hFFFFFFFF, "R9");
    rdw(4'd4, 32'h4444, "R9");
    step(1'b0, 0, 0, 0, 4'd4, 2'd1, 4'd6, 2'd3, "R9");
    wr(4'd15, 2'd2, 32'hFFFF, "R9");
    rdw(4'd15, 32'h0, "R9");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] ws, as, bs;
      logic [1:0] wz, az, bz;
      logic [31:0] wd;
      ws = 4'($urandom % 16);
      wz = ($urandom % 4 == 0) ? 2'($urandom % 4) : 2'd2;
      if (ws == 14 && $urandom % 3 != 0) ws = 4'($urandom % 4);
      wd = $urandom;
      as = 4'($urandom % 16); az = 2'($urandom % 4);
      bs = 4'($urandom % 16); bz = 2'd2;
      step(1'b1, ws, wz, wd, as, az, bs, bz, req_of(as, az));
    end

    // R1: reset again after activity
    @(negedge clk); rst = 1; wr_en = 0;
    @(posedge clk); m_reset();
    @(negedge clk); rst = 0;
    rdw(4'd14, 32'h0, "R1");
    rdw(4'd10, 32'h0, "R1");
    rdw(4'd0, 32'h0, "R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule